// File: doc/BRIEF.md
# Long-Run Repetition Health Monitor

This block watches a stream of random bits as they are produced and checks each run of identical consecutive bits. When a run grows to a programmable length, the monitor records it as a long run. The result is a sticky flag and a saturating 8-bit event count, which the surrounding register logic can read. A healthy entropy source should almost never produce such runs. A rising count therefore warns that the source may be stuck or biased.

Each accepted bit updates the run length in the cycle it is sampled, and the flag and count outputs show the result one clock later. A small configuration holder keeps the threshold and the test-enable bit. Both come up at their default values after reset and can be rewritten with a single write strobe. Dropping the generator enable clears the run tracking, the flag and the count, so every new generation session starts clean.

Top module: `lr_health_mon`

## Requirements
- R1: After reset, `long_flag` is 0, `long_count` is 0, the threshold is 26 and the test is enabled. A run of 25 equal bits raises nothing, and the 26th equal bit raises the flag and the count.
- R2: Only bits with `bit_vld` high take part. A bit that differs from the previous accepted bit restarts the run length at 1. Cycles with `bit_vld` low neither extend nor break a run.
- R3: A run qualifies when its length is greater than or equal to the threshold. It is counted once, in the cycle its length first equals the threshold. The outputs change on the clock edge that samples that bit.
- R4: The run length saturates at 31. With the threshold at 31, a run of any length beyond 31 adds exactly one to the count.
- R5: `long_count` increases by one per qualifying run and holds at 255 instead of wrapping.
- R6: `long_flag` goes to 1 with the first counted long run. It stays at 1 until the generator is disabled or the block is reset.
- R7: While the test is disabled, no run is counted. Run tracking continues, so a run that already passed the threshold when the test is re-enabled is not counted.
- R8: While `gen_en` is low, the flag, the count and the run tracking are cleared. The first accepted bit after re-enabling starts a run of length 1, whatever its value.
- R9: A threshold of 0 behaves like a threshold of 1: every run qualifies on its first bit.
- R10: With `cfg_we` high, `cfg_thr` and `cfg_test_en` are stored on that clock edge. They apply to bits sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Generator enable; low clears results and run state |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Random bit under test |
| cfg_we | input | 1 | Write strobe for the configuration |
| cfg_thr | input | 5 | New long-run threshold |
| cfg_test_en | input | 1 | New test-enable value |
| long_flag | output | 1 | Sticky: at least one long run seen |
| long_count | output | 8 | Saturating count of long runs |

## Verification
Two states are hard to reach from the ports, and both need long stretches of stimulus. One is count saturation: the bench sets the threshold to 1 and feeds several hundred alternating bits, so every bit opens a qualifying run and the count is driven past 255. The other is run-length saturation: the bench sets the threshold to 31 and holds a single value for 80 bits, which shows that the stuck-at-31 length never produces a second event. A behavioural model with an unbounded integer run length is compared with the outputs on every clock through threshold changes, test-enable toggles and generator-disable pulses.

// File: rtl/lr_pkg.sv
package lr_pkg;

    localparam int LR_THR_W   = 5;
    localparam int LR_CNT_W   = 8;
    localparam int LR_THR_RST = 26;

    // What the tracker did with the current cycle's bit
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,   // no accepted bit
        STEP_NEW  = 2'd1,   // bit opened a fresh run
        STEP_GROW = 2'd2,   // bit extended a run below saturation
        STEP_HOLD = 2'd3    // bit extended a run already saturated
    } step_e;

    // A step can produce an event only when the run length actually moved
    function automatic logic step_moves(input step_e k);
        return (k == STEP_NEW) || (k == STEP_GROW);
    endfunction

endpackage

// File: rtl/lr_cfg_reg.sv
module lr_cfg_reg
    import lr_pkg::*;
#(
    parameter int THR_W   = LR_THR_W,
    parameter int THR_RST = LR_THR_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic             cfg_test_en,
    output logic [THR_W-1:0] thr_q,
    output logic             ten_q
);

    localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= THR_INIT;
            ten_q <= 1'b1;
        end else if (cfg_we) begin
            thr_q <= cfg_thr;
            ten_q <= cfg_test_en;
        end
    end

    // R10: a write lands on the edge of the strobe
    a_r10_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (thr_q == $past(cfg_thr) && ten_q == $past(cfg_test_en)));

endmodule

// File: rtl/lr_run_tracker.sv
module lr_run_tracker
    import lr_pkg::*;
#(
    parameter int LEN_W = LR_THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             bit_vld,
    input  logic             bit_in,
    output step_e            step,
    output logic [LEN_W-1:0] len_nxt
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic             have_q;   // a run is in progress
    logic             last_q;   // value of that run
    logic [LEN_W-1:0] len_q;

    always_comb begin
        step    = STEP_IDLE;
        len_nxt = len_q;
        if (gen_en && bit_vld) begin
            if (!have_q || (bit_in != last_q)) begin
                step    = STEP_NEW;
                len_nxt = LEN_ONE;
            end else if (len_q == LEN_MAX) begin
                step    = STEP_HOLD;
            end else begin
                step    = STEP_GROW;
                len_nxt = len_q + LEN_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !gen_en) begin
            have_q <= 1'b0;
            last_q <= 1'b0;
            len_q  <= '0;
        end else if (step != STEP_IDLE) begin
            have_q <= 1'b1;
            last_q <= bit_in;
            len_q  <= len_nxt;
        end
    end

    // R4: a saturated run stays saturated while the same value continues
    a_r4_len_saturates: assert property (@(posedge clk) disable iff (rst)
        (gen_en && bit_vld && have_q && bit_in == last_q && len_q == LEN_MAX)
            |=> (len_q == LEN_MAX));

    // R2: a change of value restarts the run at one
    a_r2_restart_one: assert property (@(posedge clk) disable iff (rst)
        (gen_en && bit_vld && have_q && bit_in != last_q) |=> (len_q == LEN_ONE));

    // R2: idle cycles leave the run untouched
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (gen_en && !bit_vld) |=> ($stable(len_q) && $stable(last_q)));

endmodule

// File: rtl/lr_thr_cmp.sv
module lr_thr_cmp
    import lr_pkg::*;
#(
    parameter int THR_W = LR_THR_W
) (
    input  logic [THR_W-1:0] thr,
    input  logic             ten,
    input  step_e            step,
    input  logic [THR_W-1:0] len_nxt,
    output logic             hit
);

    logic [THR_W-1:0] thr_eff;

    // A zero threshold would otherwise never equal a run length
    assign thr_eff = (thr == '0) ? THR_W'(1) : thr;
    assign hit     = ten && step_moves(step) && (len_nxt == thr_eff);

endmodule

// File: rtl/lr_event_log.sv
module lr_event_log
    import lr_pkg::*;
#(
    parameter int CNT_W = LR_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             hit,
    output logic             flag_q,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || !gen_en) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (hit) begin
            flag_q <= 1'b1;
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (gen_en && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (gen_en && flag_q) |=> flag_q);

    a_r6_flag_has_count: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> (cnt_q != '0));

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> (!flag_q && cnt_q == '0));

endmodule

// File: rtl/lr_health_mon.sv
module lr_health_mon
    import lr_pkg::*;
#(
    parameter int THR_W   = LR_THR_W,
    parameter int CNT_W   = LR_CNT_W,
    parameter int THR_RST = LR_THR_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             cfg_we,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic             cfg_test_en,
    output logic             long_flag,
    output logic [CNT_W-1:0] long_count
);

    logic [THR_W-1:0] thr_q;
    logic             ten_q;
    step_e            step;
    logic [THR_W-1:0] len_nxt;
    logic             hit;

    lr_cfg_reg #(.THR_W(THR_W), .THR_RST(THR_RST)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_thr     (cfg_thr),
        .cfg_test_en (cfg_test_en),
        .thr_q       (thr_q),
        .ten_q       (ten_q)
    );

    lr_run_tracker #(.LEN_W(THR_W)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .gen_en  (gen_en),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .step    (step),
        .len_nxt (len_nxt)
    );

    lr_thr_cmp #(.THR_W(THR_W)) u_cmp (
        .thr     (thr_q),
        .ten     (ten_q),
        .step    (step),
        .len_nxt (len_nxt),
        .hit     (hit)
    );

    lr_event_log #(.CNT_W(CNT_W)) u_log (
        .clk    (clk),
        .rst    (rst),
        .gen_en (gen_en),
        .hit    (hit),
        .flag_q (long_flag),
        .cnt_q  (long_count)
    );

    // R7: with the test off, the count cannot move
    a_r7_off_no_count: assert property (@(posedge clk) disable iff (rst)
        (gen_en && !ten_q) |=> $stable(long_count));

endmodule

// File: tb/sim_lr_health_mon.sv
module sim_lr_health_mon;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gen_en = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_thr = 5'd0;
    logic       cfg_test_en = 1'b0;
    logic       long_flag;
    logic [7:0] long_count;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // reference model state
    int m_len, m_thr, m_cnt;
    bit m_have, m_last, m_ten, m_flag;

    always #5 clk = ~clk;

    lr_health_mon u0 (
        .clk         (clk),
        .rst         (rst),
        .gen_en      (gen_en),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .cfg_we      (cfg_we),
        .cfg_thr     (cfg_thr),
        .cfg_test_en (cfg_test_en),
        .long_flag   (long_flag),
        .long_count  (long_count)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_have = 0; m_last = 0; m_len = 0;
            m_flag = 0; m_cnt = 0; m_thr = 26; m_ten = 1;
        end else begin
            if (!gen_en) begin
                m_have = 0; m_len = 0; m_flag = 0; m_cnt = 0;
            end else if (bit_vld) begin
                if (!m_have || bit_in != m_last) m_len = 1;
                else m_len = m_len + 1;
                m_have = 1;
                m_last = bit_in;
                if (m_ten && m_len == ((m_thr == 0) ? 1 : m_thr)) begin
                    m_flag = 1;
                    if (m_cnt < 255) m_cnt = m_cnt + 1;
                end
            end
            if (cfg_we) begin
                m_thr = int'(cfg_thr);
                m_ten = cfg_test_en;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        if (!rst) begin
            check(cur_req, "flag vs model", int'(long_flag), int'(m_flag));
            check(cur_req, "count vs model", int'(long_count), m_cnt);
        end
    endtask

    task automatic step(input logic v, input logic b);
        @(negedge clk);
        compare_model();
        bit_vld = v;
        bit_in  = b;
        cfg_we  = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 1'b0);
    endtask

    task automatic run(input int n, input logic b);
        for (int i = 0; i < n; i++) step(1'b1, b);
    endtask

    task automatic write_cfg(input int thr, input logic ten);
        @(negedge clk);
        compare_model();
        bit_vld     = 1'b0;
        cfg_we      = 1'b1;
        cfg_thr     = 5'(thr);
        cfg_test_en = ten;
        idle();
    endtask

    task automatic expect_out(input string req, input int f, input int c);
        check(req, "flag", int'(long_flag), f);
        check(req, "count", int'(long_count), c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        expect_out("R1", 0, 0);

        cur_req = "R1";
        run(25, 1'b1); idle();
        expect_out("R1", 0, 0);
        run(1, 1'b1); idle();
        expect_out("R6", 1, 1);

        cur_req = "R3";
        run(10, 1'b1); idle();
        expect_out("R3", 1, 1);
        run(26, 1'b0); idle();
        expect_out("R3", 1, 2);

        cur_req = "R10";
        write_cfg(4, 1'b1);
        run(1, 1'b0);
        run(3, 1'b1); idle();
        expect_out("R10", 1, 2);
        run(1, 1'b1); idle();
        expect_out("R10", 1, 3);

        cur_req = "R2";
        run(2, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        run(1, 1'b0); idle();
        expect_out("R2", 1, 3);
        run(1, 1'b0); idle();
        expect_out("R2", 1, 4);
        run(3, 1'b1); run(1, 1'b0); run(3, 1'b1); idle();
        expect_out("R2", 1, 4);

        cur_req = "R7";
        write_cfg(4, 1'b0);
        run(1, 1'b1);
        run(6, 1'b0);
        write_cfg(4, 1'b1);
        run(3, 1'b0); idle();
        expect_out("R7", 1, 4);
        run(4, 1'b1); idle();
        expect_out("R7", 1, 5);

        cur_req = "R9";
        write_cfg(0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            run(1, 1'b0);
            run(1, 1'b1);
        end
        run(1, 1'b1); idle();
        expect_out("R9", 1, 11);
        write_cfg(1, 1'b1);
        run(1, 1'b0); idle();
        expect_out("R9", 1, 12);

        cur_req = "R4";
        write_cfg(31, 1'b1);
        run(80, 1'b1); idle();
        expect_out("R4", 1, 13);
        run(31, 1'b0); idle();
        expect_out("R4", 1, 14);

        cur_req = "R8";
        @(negedge clk);
        compare_model();
        gen_en = 1'b0;
        idle(); idle();
        expect_out("R8", 0, 0);
        gen_en = 1'b1;
        write_cfg(2, 1'b1);
        run(1, 1'b0); idle();
        expect_out("R8", 0, 0);
        run(1, 1'b0); idle();
        expect_out("R8", 1, 1);

        cur_req = "R5";
        write_cfg(1, 1'b1);
        for (int i = 0; i < 300; i++) step(1'b1, 1'(i % 2));
        idle();
        expect_out("R5", 1, 255);
        idle();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule